// File: doc/BRIEF.md
# Sprite Table Page DMA

This block copies a whole sprite attribute table out of system memory in one burst. Software writes one byte into the block's page register, and that write also starts the copy. The byte is the upper half of the source address, so each copy begins at a 256-byte boundary. The engine then reads one byte per cycle from system memory and writes each byte into the sprite attribute memory. It always fills the table from its first entry.

System memory answers each read exactly one cycle later. The block registers the returned byte before it writes it to the sprite memory, so every byte spends two cycles in flight. A `busy` output covers the whole copy. A new page write during a copy abandons the old copy and starts again from the new page.

Top module: `spr_page_dma`

## Requirements
- R1: A cycle with `cfg_we` high stores `cfg_wdata` in the page register. `cfg_rdata` shows the stored value from the next cycle on, and `busy` is high in that next cycle.
- R2: Every read places the page register on `mem_rd_addr[15:8]` and the table offset on `mem_rd_addr[7:0]`. The first read after a trigger uses offset 0 and comes in the first cycle after the trigger.
- R3: Each trigger that is not interrupted produces exactly 160 writes to the sprite memory, at table offsets 0 to 159, and no others.
- R4: The byte written at table offset N equals the system-memory byte at page*256 + N.
- R5: Writes come one per cycle, with no gaps, in ascending offset order. Each write occurs two cycles after the read of the same offset.
- R6: `busy` stays high from the cycle after the trigger through the cycle of the last write, 162 cycles in all. It is low in the following cycle and stays low, with no reads or writes, until the next trigger.
- R7: A trigger during a copy discards every read still in flight from the old page. It then runs a complete copy of the new page from offset 0.
- R8: A synchronous active-high `rst` clears `busy` and the page register and stops all reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Page register write strobe; starts a copy |
| cfg_wdata | input | 8 | Source page number |
| cfg_rdata | output | 8 | Page register read-back |
| mem_rd_en | output | 1 | System-memory read request |
| mem_rd_addr | output | 16 | System-memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| spr_wr_en | output | 1 | Sprite memory write strobe |
| spr_wr_addr | output | 8 | Sprite table offset |
| spr_wr_data | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress |

## Verification
The assertions on the data path assume a fixed one-cycle latency. They check each written byte against the `mem_rd_data` value of the cycle before it, and they check each write offset against the read address issued two cycles earlier. The bench's memory model meets this assumption: it returns a byte, computed from the address, on the edge after every request and never stalls. The check on the falling edge of `busy` ignores the cycle right after reset. The bench holds reset for at least two cycles, so reset never looks like a finished copy.

// File: rtl/spr_page_dma.sv
module spr_page_dma #(
  parameter int PAGE_W     = 8,
  parameter int PAGE_SHIFT = 8,
  parameter int DATA_W     = 8,
  parameter int TBL_LEN    = 160,
  localparam int ADDR_W    = PAGE_W + PAGE_SHIFT,
  localparam int TBL_AW    = $clog2(TBL_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [PAGE_W-1:0] cfg_rdata,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              spr_wr_en,
  output logic [TBL_AW-1:0] spr_wr_addr,
  output logic [DATA_W-1:0] spr_wr_data,
  output logic              busy
);
  localparam logic [TBL_AW-1:0] LAST = TBL_AW'(TBL_LEN - 1);

  logic [PAGE_W-1:0] page_q;
  logic              issue_q;
  logic [TBL_AW-1:0] rd_ofs_q;
  logic              s1_v_q, s2_v_q;
  logic [TBL_AW-1:0] s1_ofs_q, s2_ofs_q;
  logic [DATA_W-1:0] s2_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      issue_q  <= 1'b0;
      rd_ofs_q <= '0;
      s1_v_q   <= 1'b0;
      s2_v_q   <= 1'b0;
      s1_ofs_q <= '0;
      s2_ofs_q <= '0;
    end else if (cfg_we) begin
      page_q   <= cfg_wdata;
      issue_q  <= 1'b1;
      rd_ofs_q <= '0;
      s1_v_q   <= 1'b0;
      s2_v_q   <= 1'b0;
    end else begin
      if (issue_q) begin
        rd_ofs_q <= rd_ofs_q + 1'b1;
        if (rd_ofs_q == LAST) issue_q <= 1'b0;
      end
      s1_v_q   <= issue_q;
      s1_ofs_q <= rd_ofs_q;
      s2_v_q   <= s1_v_q;
      s2_ofs_q <= s1_ofs_q;
    end
  end

  always_ff @(posedge clk) s2_data_q <= mem_rd_data;

  assign cfg_rdata   = page_q;
  assign mem_rd_en   = issue_q;
  assign mem_rd_addr = {page_q, PAGE_SHIFT'(rd_ofs_q)};
  assign spr_wr_en   = s2_v_q;
  assign spr_wr_addr = s2_ofs_q;
  assign spr_wr_data = s2_data_q;
  assign busy        = issue_q | s1_v_q | s2_v_q;
endmodule

// File: rtl/spr_page_dma_chk.sv
module spr_page_dma_chk #(
  parameter int PAGE_W     = 8,
  parameter int PAGE_SHIFT = 8,
  parameter int DATA_W     = 8,
  parameter int TBL_LEN    = 160,
  localparam int ADDR_W    = PAGE_W + PAGE_SHIFT,
  localparam int TBL_AW    = $clog2(TBL_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [PAGE_W-1:0] cfg_wdata,
  input logic [PAGE_W-1:0] cfg_rdata,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic              spr_wr_en,
  input logic [TBL_AW-1:0] spr_wr_addr,
  input logic [DATA_W-1:0] spr_wr_data,
  input logic              busy
);
  // R1
  trig_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> busy && cfg_rdata == $past(cfg_wdata));
  // R2
  rd_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> mem_rd_addr[ADDR_W-1:PAGE_SHIFT] == cfg_rdata
                  && mem_rd_addr[PAGE_SHIFT-1:0] < PAGE_SHIFT'(TBL_LEN));
  // R3
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    spr_wr_en |-> spr_wr_addr < TBL_AW'(TBL_LEN - 1) || spr_wr_addr == TBL_AW'(TBL_LEN - 1));
  // R4
  wr_data_chk: assert property (@(posedge clk) disable iff (rst)
    spr_wr_en |-> spr_wr_data == $past(mem_rd_data));
  // R5
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    spr_wr_en |-> $past(mem_rd_en, 2) && spr_wr_addr == TBL_AW'($past(mem_rd_addr, 2)));
  // R5
  wr_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    spr_wr_en && $past(spr_wr_en) |-> spr_wr_addr == $past(spr_wr_addr) + 1'b1);
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) && !$past(rst) |->
      $past(spr_wr_en) && $past(spr_wr_addr) == TBL_AW'(TBL_LEN - 1));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en && !spr_wr_en);
endmodule

bind spr_page_dma spr_page_dma_chk #(
  .PAGE_W(PAGE_W), .PAGE_SHIFT(PAGE_SHIFT), .DATA_W(DATA_W), .TBL_LEN(TBL_LEN)
) chk_i (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .mem_rd_data(mem_rd_data), .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr),
  .spr_wr_data(spr_wr_data), .busy(busy)
);

// File: tb/spr_page_dma_tb.sv
module spr_page_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        spr_wr_en;
  logic [7:0]  spr_wr_addr;
  logic [7:0]  spr_wr_data;
  logic        busy;

  always #10 clk = ~clk;

  spr_page_dma dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr),
    .spr_wr_data(spr_wr_data), .busy(busy)
  );

  typedef struct { logic [7:0] a; logic [7:0] d; } item_t;
  item_t      exp_q[$];
  logic [7:0] cur_page = '0;
  int         rd_exp = 0;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd3;
    return a[15:8] ^ m ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_rd_addr);

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard pops at each falling edge
  always @(negedge clk) if (!rst) begin
    if (spr_wr_en) begin
      if (exp_q.size() == 0) chk(0, "R3", "write with nothing expected", spr_wr_addr, 999);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(spr_wr_addr == it.a, "R5", "write offset", spr_wr_addr, it.a);
        chk(spr_wr_data == it.d, "R4", "write data", spr_wr_data, it.d);
      end
    end
    if (mem_rd_en) begin
      chk(mem_rd_addr == {cur_page, rd_exp[7:0]} && rd_exp < 160, "R2", "read address",
          mem_rd_addr, {cur_page, rd_exp[7:0]});
      rd_exp++;
    end
  end

  task automatic trigger(logic [7:0] page);
    @(negedge clk); #1;
    exp_q.delete();
    for (int n = 0; n < 160; n++) exp_q.push_back('{a: 8'(n), d: mem_byte({page, 8'(n)})});
    cur_page = page;
    rd_exp = 0;
    cfg_we = 1'b1;
    cfg_wdata = page;
    @(negedge clk);
    chk(busy == 1'b1, "R1", "busy after trigger", busy, 1);
    chk(cfg_rdata == page, "R1", "page read-back", cfg_rdata, page);
    #1 cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    int cnt = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy) cnt++;
      else break;
    end
    chk(cnt == 162, "R6", "busy cycle count", cnt, 162);
    chk(exp_q.size() == 0, "R3", "writes left unseen", exp_q.size(), 0);
  endtask

  task automatic idle_check(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!busy && !mem_rd_en && !spr_wr_en, req, "idle outputs",
          {busy, mem_rd_en, spr_wr_en}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy in reset", busy, 0);
    chk(cfg_rdata == 8'h00, "R8", "page in reset", cfg_rdata, 0);
    #1 rst = 1'b0;
    idle_check(3, "R8");

    trigger(8'h12); wait_done(); idle_check(6, "R6");
    trigger(8'h00); wait_done();
    trigger(8'hFF); wait_done(); idle_check(2, "R6");

    // R7: restart during a copy
    trigger(8'h34);
    repeat (40) @(negedge clk);
    trigger(8'hA7); wait_done(); idle_check(3, "R7");
    // R7: restart while the last bytes are in flight
    trigger(8'h55);
    repeat (159) @(negedge clk);
    trigger(8'h56); wait_done();

    // R8: reset in the middle of a copy
    trigger(8'hC3);
    repeat (20) @(negedge clk);
    #1 rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R8", "busy after reset", busy, 0);
    chk(cfg_rdata == 8'h00, "R8", "page after reset", cfg_rdata, 0);
    chk(!mem_rd_en && !spr_wr_en, "R8", "enables after reset", {mem_rd_en, spr_wr_en}, 0);
    #1 rst = 1'b0;
    idle_check(4, "R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule